// File: doc/BRIEF.md
# Serial Receive Byte Queue with Idle Timeout

This block buffers the characters that a serial receiver delivers until the processor reads them. By default it holds up to sixteen bytes in arrival order. It keeps the line-status flags that belong to the receive side: data present, lost character and line break. It also produces two interrupt-side indications. The first is a flag raised once the number of stored bytes reaches a level chosen by software. The second is a pending flag raised when bytes sit unread while the line has been quiet for four character times.

Software controls the queue through one control-byte write. Bit 0 turns the queue on. Bit 1 empties it. Bits 7:6 select the trigger level. With the queue off, the block acts as a single holding byte. The character time is supplied as a count of clock cycles. The receive shifter and baud generation are outside the block.

Top module: `rx_char_buffer`

## Requirements
- R1: With the queue on (control bit 0 = 1), accepted bytes are returned in arrival order. `level` gives the number stored, up to DEPTH. `rd_data` shows, during a `data_rd` cycle, the byte that the read removes.
- R2: Control bits 7:6 select the trigger level: 00→1, 01→4, 10→8, 11→14 bytes. With the queue on, `trig_hit` is 1 when data is ready and `level` is at least the selected count. With the queue off, `trig_hit` follows `data_ready`.
- R3: A byte that arrives while the queue holds DEPTH bytes and no read happens in that cycle is dropped. `overrun` is set, and the stored bytes and their order are unchanged.
- R4: A `rx_break` pulse stores a 0x00 byte and sets both `brk` and `data_ready`. A break in the same cycle as `rx_valid` takes precedence and the byte is ignored.
- R5: The idle timer reloads to 4×`char_cycles` on every received byte, and on every read that leaves data in the queue. `timeout_pend` rises exactly 4×`char_cycles` cycles after the reload edge if data is still stored, and stays low if the queue is empty then.
- R6: Every `data_rd` clears `timeout_pend`. A read that leaves the queue empty clears `data_ready` and `brk`. A read of an empty queue returns 0x00.
- R7: A control write with bit 1 set empties the queue, clears `data_ready`, `brk` and `timeout_pend`, and stops the timer. Arrivals and reads in that same cycle are ignored.
- R8: A control write that changes bit 0 flushes the queue as in R7 even when bit 1 is 0. A write that keeps bit 0 and has bit 1 clear leaves the stored bytes in place.
- R9: With the queue off, one holding byte is kept. A byte arriving while `data_ready` is 1 replaces it and sets `overrun`. A read returns it and clears `data_ready`.
- R10: An `lsr_rd` pulse clears `overrun` and `brk` and leaves `data_ready` unchanged.
- R11: After reset the queue is off and empty, and `data_ready`, `overrun`, `brk`, `trig_hit` and `timeout_pend` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Line break detected |
| fcr_wr | input | 1 | Control-byte write strobe |
| fcr_data | input | 8 | Control byte: bit 0 queue on, bit 1 flush, bits 7:6 trigger select |
| data_rd | input | 1 | Processor reads the data register |
| lsr_rd | input | 1 | Processor reads the line status |
| char_cycles | input | 16 | Clock cycles per character time |
| rd_data | output | 8 | Byte returned by a read in the current cycle |
| data_ready | output | 1 | Received data available |
| overrun | output | 1 | A byte was lost |
| brk | output | 1 | Break received |
| level | output | 5 | Bytes stored in the queue |
| trig_hit | output | 1 | Trigger level reached |
| timeout_pend | output | 1 | Idle timeout pending |
| fifo_on | output | 1 | Queue enabled |

## Verification
The hardest state to reach is the idle timeout landing on the exact cycle while data remains stored, after a partial read has reloaded the timer. The stimulus sets a small character time, queues two bytes, reads one after a few idle cycles, and then samples `timeout_pend` one cycle before and on the cycle the reload should expire. A full queue is reached by sixteen back-to-back arrivals. A seventeenth arrival then probes the dropped-byte rule, and draining the queue confirms that every stored byte is intact and in order.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  localparam int CTRL_ON_BIT   = 0;
  localparam int CTRL_FLUSH_BIT = 1;
  localparam int CTRL_TRIG_LSB = 6;

  typedef enum logic [1:0] {
    TRIG_ONE   = 2'b00,
    TRIG_FOUR  = 2'b01,
    TRIG_EIGHT = 2'b10,
    TRIG_FOURTEEN = 2'b11
  } trig_sel_e;

  // Number of stored bytes that raises the trigger flag.
  function automatic logic [7:0] trig_depth(input trig_sel_e sel);
    case (sel)
      TRIG_ONE:   trig_depth = 8'd1;
      TRIG_FOUR:  trig_depth = 8'd4;
      TRIG_EIGHT: trig_depth = 8'd8;
      default:    trig_depth = 8'd14;
    endcase
  endfunction

endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] count,
  output logic             full
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_pop, do_push;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    ptr_next = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign do_push = push && (!full || do_pop);
  assign head    = (count == '0) ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

endmodule

// File: rtl/rxbuf_idle_timer.sv
module rxbuf_idle_timer #(
  parameter int CYC_W = 16,
  localparam int TW   = CYC_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             stop,
  input  logic [CYC_W-1:0] char_cycles,
  output logic             expire
);

  logic [TW-1:0] remain;

  // Four character times.
  function automatic logic [TW-1:0] idle_span(input logic [CYC_W-1:0] c);
    idle_span = {c, 2'b00};
  endfunction

  assign expire = (remain == TW'(1)) && !restart && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (stop)            remain <= '0;
    else if (restart)         remain <= idle_span(char_cycles);
    else if (remain != '0)    remain <= remain - TW'(1);
  end

endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rxbuf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CYC_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_byte,
  input  logic             rx_break,
  input  logic             fcr_wr,
  input  logic [7:0]       fcr_data,
  input  logic             data_rd,
  input  logic             lsr_rd,
  input  logic [CYC_W-1:0] char_cycles,
  output logic [DW-1:0]    rd_data,
  output logic             data_ready,
  output logic             overrun,
  output logic             brk,
  output logic [CNT_W-1:0] level,
  output logic             trig_hit,
  output logic             timeout_pend,
  output logic             fifo_on
);

  trig_sel_e     trig_sel;
  logic [DW-1:0] hold_byte;

  // Named internal events (observed by the checker).
  logic on_change, flush_evt;
  logic take_rx, take_brk, take_rd, arrive;
  logic q_push, q_pop, q_full;
  logic [DW-1:0] q_din, q_head;
  logic ovf_evt, rd_empties, tmr_restart, tmr_expire;

  assign on_change = fcr_wr && (fcr_data[CTRL_ON_BIT] != fifo_on);
  assign flush_evt = fcr_wr && (fcr_data[CTRL_FLUSH_BIT] || on_change);

  assign take_brk = rx_break && !flush_evt;
  assign take_rx  = rx_valid && !rx_break && !flush_evt;
  assign take_rd  = data_rd && !flush_evt;
  assign arrive   = take_rx || take_brk;

  assign q_push = fifo_on && arrive;
  assign q_pop  = fifo_on && take_rd;
  assign q_din  = take_brk ? '0 : rx_byte;

  rxbuf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flush_evt),
    .push  (q_push),
    .din   (q_din),
    .pop   (q_pop),
    .head  (q_head),
    .count (level),
    .full  (q_full)
  );

  assign ovf_evt = fifo_on ? (q_push && q_full && !q_pop)
                           : (arrive && data_ready && !take_rd);

  assign rd_empties = take_rd &&
                      (fifo_on ? ((level <= CNT_W'(1)) && !q_push) : !arrive);

  assign tmr_restart = fifo_on && (take_rx || (take_rd && (level > CNT_W'(1))));

  rxbuf_idle_timer #(.CYC_W(CYC_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (tmr_restart),
    .stop        (flush_evt),
    .char_cycles (char_cycles),
    .expire      (tmr_expire)
  );

  assign rd_data  = fifo_on ? q_head : hold_byte;
  assign trig_hit = data_ready &&
                    (!fifo_on || (level >= CNT_W'(trig_depth(trig_sel))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_on  <= 1'b0;
      trig_sel <= TRIG_ONE;
    end else if (fcr_wr) begin
      fifo_on  <= fcr_data[CTRL_ON_BIT];
      trig_sel <= trig_sel_e'(fcr_data[CTRL_TRIG_LSB +: 2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    hold_byte <= '0;
    else if (!fifo_on && take_brk) hold_byte <= '0;
    else if (!fifo_on && take_rx)  hold_byte <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_ready   <= 1'b0;
      brk          <= 1'b0;
      overrun      <= 1'b0;
      timeout_pend <= 1'b0;
    end else begin
      if (flush_evt)       data_ready <= 1'b0;
      else if (arrive)     data_ready <= 1'b1;
      else if (rd_empties) data_ready <= 1'b0;

      if (flush_evt)                   brk <= 1'b0;
      else if (take_brk)               brk <= 1'b1;
      else if (rd_empties || lsr_rd)   brk <= 1'b0;

      if (ovf_evt)     overrun <= 1'b1;
      else if (lsr_rd) overrun <= 1'b0;

      if (flush_evt || take_rd)                  timeout_pend <= 1'b0;
      else if (tmr_expire && (level != '0))      timeout_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/rxbuf_chk.sv
module rxbuf_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rx_break,
  input logic             fcr_wr,
  input logic [7:0]       fcr_data,
  input logic             data_rd,
  input logic             lsr_rd,
  input logic             data_ready,
  input logic             overrun,
  input logic             brk,
  input logic [CNT_W-1:0] level,
  input logic             timeout_pend,
  input logic             fifo_on,
  input logic             tmr_expire
);

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));

  a_r3_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_on && level == CNT_W'(DEPTH) && rx_valid && !data_rd && !fcr_wr
    |=> level == CNT_W'(DEPTH) && overrun);

  a_r4_break_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break && !fcr_wr |=> brk && data_ready);

  a_r5_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expire && level != '0 && !data_rd && !fcr_wr |=> timeout_pend);

  a_r5_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_pend) |-> level != '0);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> !timeout_pend);

  a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr && fcr_data[1] |=> level == '0 && !data_ready && !brk && !timeout_pend);

  a_r8_toggle_flush: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr && (fcr_data[0] != fifo_on) |=> level == '0 && !data_ready);

  a_r10_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !rx_valid && !rx_break |=> !overrun && !brk);

endmodule

bind rx_char_buffer rxbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_valid     (rx_valid),
  .rx_break     (rx_break),
  .fcr_wr       (fcr_wr),
  .fcr_data     (fcr_data),
  .data_rd      (data_rd),
  .lsr_rd       (lsr_rd),
  .data_ready   (data_ready),
  .overrun      (overrun),
  .brk          (brk),
  .level        (level),
  .timeout_pend (timeout_pend),
  .fifo_on      (fifo_on),
  .tmr_expire   (tmr_expire)
);

// File: tb/sim_rx_char_buffer.sv
`timescale 1ns/1ps
module sim_rx_char_buffer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_break = 1'b0, fcr_wr = 1'b0;
  logic        data_rd = 1'b0, lsr_rd = 1'b0;
  logic [7:0]  rx_byte = '0, fcr_data = '0;
  logic [15:0] char_cycles = 16'd3;
  logic [7:0]  rd_data;
  logic        data_ready, overrun, brk, trig_hit, timeout_pend, fifo_on;
  logic [4:0]  level;

  int checks = 0;
  int failures = 0;

  // {control byte (flush + on + trigger select), expected trigger depth}
  localparam logic [15:0] TRIG_TAB [4] = '{16'h0301, 16'h4304, 16'h8308, 16'hC30E};

  always #4 clk = ~clk;

  rx_char_buffer u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_break(rx_break), .fcr_wr(fcr_wr), .fcr_data(fcr_data),
    .data_rd(data_rd), .lsr_rd(lsr_rd), .char_cycles(char_cycles),
    .rd_data(rd_data), .data_ready(data_ready), .overrun(overrun), .brk(brk),
    .level(level), .trig_hit(trig_hit), .timeout_pend(timeout_pend),
    .fifo_on(fifo_on)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic brk_pulse();
    rx_break = 1'b1;
    @(negedge clk);
    rx_break = 1'b0;
  endtask

  task automatic ctrl(input logic [7:0] v);
    fcr_data = v; fcr_wr = 1'b1;
    @(negedge clk);
    fcr_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    data_rd = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    data_rd = 1'b0;
  endtask

  task automatic status_rd();
    lsr_rd = 1'b1;
    @(negedge clk);
    lsr_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R11 reset state
    chk("R11 fifo_on", fifo_on, 0);
    chk("R11 level", level, 0);
    chk("R11 flags", {data_ready, overrun, brk, trig_hit, timeout_pend}, 0);

    // R2 trigger levels, table walk
    for (int i = 0; i < 4; i++) begin
      ctrl(TRIG_TAB[i][15:8]);
      for (int k = 0; k < int'(TRIG_TAB[i][7:0]) - 1; k++) push(8'(k));
      chk("R2 below level", trig_hit, 0);
      push(8'hFF);
      chk("R2 at level", trig_hit, 1);
      chk("R1 level count", level, 32'(TRIG_TAB[i][7:0]));
    end

    // R3 overrun on full, R1 order
    ctrl(8'h03);
    status_rd();
    for (int i = 0; i < 16; i++) push(8'(i + 1));
    chk("R1 full level", level, 16);
    push(8'hEE);
    chk("R3 overrun set", overrun, 1);
    chk("R3 level kept", level, 16);
    for (int i = 0; i < 16; i++) begin
      rd(v);
      chk("R1 R3 order", v, 32'(i + 1));
    end
    chk("R6 empty clears ready", data_ready, 0);
    rd(v);
    chk("R6 empty read zero", v, 0);
    status_rd();
    chk("R10 overrun cleared", overrun, 0);

    // R4 break handling
    push(8'h55);
    brk_pulse();
    chk("R4 level", level, 2);
    chk("R4 flags", {brk, data_ready}, 2'b11);
    rd(v);
    chk("R4 first byte", v, 8'h55);
    chk("R6 break kept while data", brk, 1);
    rd(v);
    chk("R4 zero byte", v, 0);
    chk("R6 break cleared on empty", {brk, data_ready}, 0);
    brk_pulse();
    status_rd();
    chk("R10 break cleared, ready kept", {brk, data_ready}, 2'b01);
    ctrl(8'h03);
    chk("R7 flush", {level, data_ready}, 0);

    // R5 timeout after a byte (4 x 3 = 12 cycles)
    push(8'h11);
    idle(11);
    chk("R5 before expiry", timeout_pend, 0);
    idle(1);
    chk("R5 at expiry", timeout_pend, 1);
    rd(v);
    chk("R6 read clears timeout", timeout_pend, 0);
    chk("R1 read value", v, 8'h11);

    // R5 reload by a partial read
    push(8'hA1);
    push(8'hA2);
    idle(5);
    rd(v);
    idle(11);
    chk("R5 reload before", timeout_pend, 0);
    idle(1);
    chk("R5 reload at expiry", timeout_pend, 1);
    rd(v);
    chk("R5 second byte", v, 8'hA2);

    // R5 no timeout with empty queue
    push(8'h33);
    rd(v);
    idle(20);
    chk("R5 empty no timeout", timeout_pend, 0);

    // R7 flush clears a pending timeout
    push(8'h44);
    idle(12);
    chk("R5 pending", timeout_pend, 1);
    ctrl(8'h03);
    chk("R7 timeout cleared", {timeout_pend, level}, 0);

    // R8 enable bit handling
    push(8'h10);
    push(8'h20);
    ctrl(8'h01);
    chk("R8 same enable keeps data", level, 2);
    ctrl(8'h00);
    chk("R8 disable flushes", {level, data_ready, fifo_on}, 0);

    // R9 single holding byte
    push(8'h5A);
    chk("R9 ready", {data_ready, overrun}, 2'b10);
    chk("R2 trig follows ready", trig_hit, 1);
    push(8'h6B);
    chk("R9 overrun", overrun, 1);
    rd(v);
    chk("R9 newest byte", v, 8'h6B);
    chk("R9 ready cleared", data_ready, 0);
    status_rd();
    chk("R10 overrun cleared", overrun, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule